// File: doc/BRIEF.md
# Segmented Register-Indirect Address Generator

This block turns the extension word of a register-indirect ALU instruction into a data memory access. It splits the word into its fields and names the destination and pointer registers in the upper bank of the register file. It forms the data address from the current pointer value, and computes the pointer value that the addressing form asks for. When the pointer wraps, it adjusts the 6-bit data-segment field held in the upper bits of the status register.

The address, the read request and both writebacks are combinational from the inputs. The enclosing pipeline qualifies the cycle with `issue`. During that cycle it reads memory at `mem_addr` when `mem_rd` is high, and commits `ptr_wdata` and `sr_wdata` to the register file when their enables are high. The ALU itself, the register file and the memory belong to the enclosing design.

When segment addressing is selected, the address places the segment field above the 16-bit pointer to make a 22-bit address. Otherwise the address is the pointer, zero-extended. The segment carry and borrow make a pointer that steps past either end of a 64K-word page move on into the next page.

Top module: `indirect_agu`

## Requirements
- R1: `dst_idx` equals 8 plus extension bits 11:9, and `ptr_idx` equals 8 plus extension bits 2:0.
- R2: With form code 0 (bits 4:3 = 00) the access uses the pointer value as given, and `ptr_we` and `sr_we` stay low.
- R3: With form code 1 (post-decrement) the access uses the old pointer, `ptr_we` is high and `ptr_wdata` is the pointer minus one modulo 2^16.
- R4: With form code 1, a pointer that steps to 0xFFFF raises `sr_we` with `sr_wdata` equal to the status value minus 0x0400 modulo 2^16, whatever extension bit 5 holds.
- R5: With form code 2 (post-increment) the access uses the old pointer and `ptr_wdata` is the pointer plus one. A result of 0x0000 raises `sr_we` with `sr_wdata` equal to the status value plus 0x0400, whatever bit 5 holds.
- R6: With form code 3 (pre-increment) `ptr_wdata` is the pointer plus one, and the access uses that new value.
- R7: With form code 3, a pointer that steps to 0x0000 adjusts the status value by +0x0400 only when bit 5 is set. The segmented address then uses the incremented segment field.
- R8: `mem_rd` is high during `issue` unless extension bits 15:12 equal 0xD (store), in which case it is low.
- R9: With bit 5 set, `mem_addr` is {status bits 15:10, access pointer}. With bit 5 clear, `mem_addr` bits 21:16 are zero and the low 16 bits are the access pointer.
- R10: While `issue` is low, `mem_rd`, `ptr_we` and `sr_we` are all low.
- R11: `sr_we` is high only when a wrap adjustment takes place, and it is never high without `ptr_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| issue | input | 1 | The instruction is executing this cycle |
| ext_word | input | 16 | Instruction extension word |
| ptr_val | input | 16 | Current value of the selected pointer register |
| sr_val | input | 16 | Current status register, segment field in bits 15:10 |
| mem_addr | output | 22 | Data memory address |
| mem_rd | output | 1 | Memory read request |
| dst_idx | output | 4 | Destination register index |
| ptr_idx | output | 4 | Pointer register index |
| ptr_wdata | output | 16 | Updated pointer value |
| ptr_we | output | 1 | Pointer writeback enable |
| sr_wdata | output | 16 | Updated status value |
| sr_we | output | 1 | Status writeback enable |

## Verification
Two things can happen in the same cycle here. A pre-increment wrap carries into the segment field, and that same carried field is used to form the segmented address. The bench provokes this with pointer 0xFFFF under form 3, with bit 5 both set and clear, and with the segment field at its maximum so that the carry also wraps. It then checks the address and the status writeback together against a model computed in the bench. Post-decrement and post-increment wraps are driven in the same way with bit 5 clear, where the status must still change while the address stays unsegmented.

// File: rtl/indirect_agu_pkg.sv
package indirect_agu_pkg;

   localparam int EXT_W     = 16;
   localparam int OP_LSB    = 12;
   localparam int OP_W      = 4;
   localparam int DST_LSB   = 9;
   localparam int SEL_W     = 3;
   localparam int SEG_BIT   = 5;
   localparam int FORM_LSB  = 3;
   localparam int PSEL_LSB  = 0;
   localparam logic [OP_W-1:0] OP_STORE = 4'hD;

   typedef enum logic [1:0] {
      FORM_PLAIN   = 2'd0,
      FORM_POSTDEC = 2'd1,
      FORM_POSTINC = 2'd2,
      FORM_PREINC  = 2'd3
   } addr_form_e;

   typedef struct packed {
      logic [OP_W-1:0]  alu_op;
      logic [SEL_W-1:0] dst_sel;
      logic             seg_en;
      addr_form_e       form;
      logic [SEL_W-1:0] ptr_sel;
   } ext_fields_t;

endpackage

// File: rtl/iag_decode.sv
module iag_decode
   import indirect_agu_pkg::*;
#(
   parameter int REG_IDX_W = 4,
   parameter int BANK_BASE = 8
) (
   input  logic [EXT_W-1:0]     ext_word,
   output ext_fields_t          fields,
   output logic [REG_IDX_W-1:0] dst_idx,
   output logic [REG_IDX_W-1:0] ptr_idx
);

   localparam int BANK_TOP = BANK_BASE + (1 << SEL_W);

   if (BANK_TOP > (1 << REG_IDX_W)) begin : g_bank_check
      $error("iag_decode: register bank does not fit the index width");
   end

   always_comb begin
      fields.alu_op  = ext_word[OP_LSB +: OP_W];
      fields.dst_sel = ext_word[DST_LSB +: SEL_W];
      fields.seg_en  = ext_word[SEG_BIT];
      fields.form    = addr_form_e'(ext_word[FORM_LSB +: 2]);
      fields.ptr_sel = ext_word[PSEL_LSB +: SEL_W];
   end

   assign dst_idx = REG_IDX_W'(BANK_BASE) + REG_IDX_W'(fields.dst_sel);
   assign ptr_idx = REG_IDX_W'(BANK_BASE) + REG_IDX_W'(fields.ptr_sel);

endmodule

// File: rtl/iag_ptr_step.sv
module iag_ptr_step
   import indirect_agu_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input  addr_form_e       form,
   input  logic [PTR_W-1:0] ptr_in,
   output logic [PTR_W-1:0] ptr_next,
   output logic [PTR_W-1:0] access_ptr,
   output logic             ptr_moves,
   output logic             wrap_up,
   output logic             wrap_down
);

   localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
   localparam logic [PTR_W-1:0] ZERO = '0;
   localparam logic [PTR_W-1:0] ALL1 = '1;

   if (PTR_W < 2) begin : g_width_check
      $error("iag_ptr_step: pointer width too small");
   end

   logic [PTR_W-1:0] ptr_inc;
   logic [PTR_W-1:0] ptr_dec;

   assign ptr_inc = ptr_in + ONE;
   assign ptr_dec = ptr_in - ONE;

   always_comb begin
      ptr_next   = ptr_in;
      access_ptr = ptr_in;
      ptr_moves  = 1'b0;
      wrap_up    = 1'b0;
      wrap_down  = 1'b0;
      unique case (form)
         FORM_PLAIN: begin
            ptr_next = ptr_in;
         end
         FORM_POSTDEC: begin
            ptr_next  = ptr_dec;
            ptr_moves = 1'b1;
            wrap_down = (ptr_dec == ALL1);
         end
         FORM_POSTINC: begin
            ptr_next  = ptr_inc;
            ptr_moves = 1'b1;
            wrap_up   = (ptr_inc == ZERO);
         end
         FORM_PREINC: begin
            ptr_next   = ptr_inc;
            access_ptr = ptr_inc;
            ptr_moves  = 1'b1;
            wrap_up    = (ptr_inc == ZERO);
         end
         default: ptr_next = ptr_in;
      endcase
   end

endmodule

// File: rtl/iag_seg_adjust.sv
module iag_seg_adjust
   import indirect_agu_pkg::*;
#(
   parameter int SR_W             = 16,
   parameter int SEG_LSB          = 10,
   parameter int SEG_W            = 6,
   parameter bit PREINC_SEG_GATED = 1'b1
) (
   input  logic [SR_W-1:0]  sr_in,
   input  addr_form_e       form,
   input  logic             seg_en,
   input  logic             wrap_up,
   input  logic             wrap_down,
   output logic [SR_W-1:0]  sr_next,
   output logic             adjust,
   output logic [SEG_W-1:0] addr_seg
);

   localparam int SEG_MSB = SEG_LSB + SEG_W - 1;

   if (SEG_MSB >= SR_W) begin : g_field_check
      $error("iag_seg_adjust: segment field exceeds status width");
   end

   logic [SEG_W-1:0] seg_old;
   logic [SEG_W-1:0] seg_new;
   logic             carry_ok;
   logic             do_inc;
   logic             do_dec;

   assign seg_old = sr_in[SEG_MSB:SEG_LSB];

   if (PREINC_SEG_GATED) begin : g_preinc_gated
      assign carry_ok = (form != FORM_PREINC) || seg_en;
   end else begin : g_preinc_free
      assign carry_ok = 1'b1;
   end

   assign do_inc = wrap_up && carry_ok;
   assign do_dec = wrap_down;
   assign adjust = do_inc || do_dec;

   always_comb begin
      seg_new = seg_old;
      if (do_inc) begin
         seg_new = seg_old + SEG_W'(1);
      end else if (do_dec) begin
         seg_new = seg_old - SEG_W'(1);
      end
   end

   always_comb begin
      sr_next = sr_in;
      sr_next[SEG_MSB:SEG_LSB] = seg_new;
   end

   // Pre-increment addresses with the already-advanced segment;
   // post forms address with the field as it stood before the step.
   assign addr_seg = (form == FORM_PREINC) ? seg_new : seg_old;

endmodule

// File: rtl/iag_addr_form.sv
module iag_addr_form #(
   parameter int PTR_W = 16,
   parameter int SEG_W = 6
) (
   input  logic                   seg_en,
   input  logic [SEG_W-1:0]       seg,
   input  logic [PTR_W-1:0]       ptr,
   output logic [SEG_W+PTR_W-1:0] addr
);

   always_comb begin
      if (seg_en) begin
         addr = {seg, ptr};
      end else begin
         addr = {{SEG_W{1'b0}}, ptr};
      end
   end

endmodule

// File: rtl/indirect_agu.sv
module indirect_agu
   import indirect_agu_pkg::*;
#(
   parameter int PTR_W            = 16,
   parameter int SR_W             = 16,
   parameter int SEG_LSB          = 10,
   parameter int SEG_W            = 6,
   parameter int REG_IDX_W        = 4,
   parameter int BANK_BASE        = 8,
   parameter bit PREINC_SEG_GATED = 1'b1,
   localparam int ADDR_W          = SEG_W + PTR_W
) (
   input  logic                 issue,
   input  logic [EXT_W-1:0]     ext_word,
   input  logic [PTR_W-1:0]     ptr_val,
   input  logic [SR_W-1:0]      sr_val,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 mem_rd,
   output logic [REG_IDX_W-1:0] dst_idx,
   output logic [REG_IDX_W-1:0] ptr_idx,
   output logic [PTR_W-1:0]     ptr_wdata,
   output logic                 ptr_we,
   output logic [SR_W-1:0]      sr_wdata,
   output logic                 sr_we
);

   ext_fields_t      fld;
   logic [PTR_W-1:0] acc_ptr;
   logic             moves;
   logic             wr_up;
   logic             wr_dn;
   logic             seg_adj;
   logic [SEG_W-1:0] seg_for_addr;

   iag_decode #(
      .REG_IDX_W (REG_IDX_W),
      .BANK_BASE (BANK_BASE)
   ) u_decode (
      .ext_word (ext_word),
      .fields   (fld),
      .dst_idx  (dst_idx),
      .ptr_idx  (ptr_idx)
   );

   iag_ptr_step #(
      .PTR_W (PTR_W)
   ) u_step (
      .form       (fld.form),
      .ptr_in     (ptr_val),
      .ptr_next   (ptr_wdata),
      .access_ptr (acc_ptr),
      .ptr_moves  (moves),
      .wrap_up    (wr_up),
      .wrap_down  (wr_dn)
   );

   iag_seg_adjust #(
      .SR_W             (SR_W),
      .SEG_LSB          (SEG_LSB),
      .SEG_W            (SEG_W),
      .PREINC_SEG_GATED (PREINC_SEG_GATED)
   ) u_seg (
      .sr_in     (sr_val),
      .form      (fld.form),
      .seg_en    (fld.seg_en),
      .wrap_up   (wr_up),
      .wrap_down (wr_dn),
      .sr_next   (sr_wdata),
      .adjust    (seg_adj),
      .addr_seg  (seg_for_addr)
   );

   iag_addr_form #(
      .PTR_W (PTR_W),
      .SEG_W (SEG_W)
   ) u_addr (
      .seg_en (fld.seg_en),
      .seg    (seg_for_addr),
      .ptr    (acc_ptr),
      .addr   (mem_addr)
   );

   assign mem_rd = issue && (fld.alu_op != OP_STORE);
   assign ptr_we = issue && moves;
   assign sr_we  = issue && seg_adj;

endmodule

// File: rtl/indirect_agu_chk.sv
module indirect_agu_chk
   import indirect_agu_pkg::*;
#(
   parameter int PTR_W     = 16,
   parameter int SR_W      = 16,
   parameter int SEG_W     = 6,
   parameter int REG_IDX_W = 4,
   localparam int ADDR_W   = SEG_W + PTR_W
) (
   input logic                 issue,
   input logic [EXT_W-1:0]     ext_word,
   input logic [PTR_W-1:0]     ptr_val,
   input logic [SR_W-1:0]      sr_val,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic                 mem_rd,
   input logic [REG_IDX_W-1:0] dst_idx,
   input logic [REG_IDX_W-1:0] ptr_idx,
   input logic [PTR_W-1:0]     ptr_wdata,
   input logic                 ptr_we,
   input logic [SR_W-1:0]      sr_wdata,
   input logic                 sr_we
);

   logic [PTR_W-1:0] pdiff;
   logic [SR_W-1:0]  sdiff;

   assign pdiff = ptr_wdata - ptr_val;
   assign sdiff = sr_wdata - sr_val;

   always_comb begin
      AST_IDLE_QUIET: assert (issue || (!mem_rd && !ptr_we && !sr_we)); // R10
      AST_UPPER_BANK: assert (dst_idx[REG_IDX_W-1] && ptr_idx[REG_IDX_W-1]); // R1
      AST_STORE_NO_READ: assert (!(issue && ext_word[OP_LSB +: OP_W] == OP_STORE) || !mem_rd); // R8
      AST_FLAT_ADDR_HIGH_ZERO: assert (ext_word[SEG_BIT] || mem_addr[ADDR_W-1:PTR_W] == '0); // R9
      AST_PTR_UNIT_STEP: assert (!ptr_we || pdiff == PTR_W'(1) || pdiff == '1); // R3
      AST_SR_NEEDS_PTR: assert (!sr_we || ptr_we); // R11
      AST_SR_SEG_STEP: assert (!sr_we || sdiff == SR_W'(16'h0400) || sdiff == SR_W'(16'hFC00)); // R4
   end

endmodule

bind indirect_agu indirect_agu_chk u_indirect_agu_chk (
   .issue     (issue),
   .ext_word  (ext_word),
   .ptr_val   (ptr_val),
   .sr_val    (sr_val),
   .mem_addr  (mem_addr),
   .mem_rd    (mem_rd),
   .dst_idx   (dst_idx),
   .ptr_idx   (ptr_idx),
   .ptr_wdata (ptr_wdata),
   .ptr_we    (ptr_we),
   .sr_wdata  (sr_wdata),
   .sr_we     (sr_we)
);

// File: tb/indirect_agu_bench.sv
module indirect_agu_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 3000;

   logic        clk;
   logic        rst_n;
   logic        issue;
   logic [15:0] ext_word;
   logic [15:0] ptr_val;
   logic [15:0] sr_val;
   logic [21:0] mem_addr;
   logic        mem_rd;
   logic [3:0]  dst_idx;
   logic [3:0]  ptr_idx;
   logic [15:0] ptr_wdata;
   logic        ptr_we;
   logic [15:0] sr_wdata;
   logic        sr_we;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   indirect_agu u_indirect_agu (
      .issue     (issue),
      .ext_word  (ext_word),
      .ptr_val   (ptr_val),
      .sr_val    (sr_val),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .dst_idx   (dst_idx),
      .ptr_idx   (ptr_idx),
      .ptr_wdata (ptr_wdata),
      .ptr_we    (ptr_we),
      .sr_wdata  (sr_wdata),
      .sr_we     (sr_we)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic [21:0] addr;
      logic        rd;
      logic [3:0]  dst;
      logic [3:0]  pix;
      logic [15:0] pw;
      logic        pwe;
      logic [15:0] sw;
      logic        swe;
   } exp_t;

   function automatic exp_t model(input logic iss, input logic [15:0] ew,
                                  input logic [15:0] p, input logic [15:0] sr);
      exp_t e;
      logic [1:0]  f;
      logic        se;
      logic [15:0] acc;
      logic [15:0] seg_src;
      f  = ew[4:3];
      se = ew[5];
      e.dst = 4'd8 + {1'b0, ew[11:9]};
      e.pix = 4'd8 + {1'b0, ew[2:0]};
      e.sw  = sr;
      e.swe = 1'b0;
      e.pwe = (f != 2'd0);
      acc   = p;
      case (f)
         2'd0: e.pw = p;
         2'd1: begin
            e.pw = p - 16'd1;
            if (e.pw == 16'hFFFF) begin e.sw = sr - 16'h0400; e.swe = 1'b1; end
         end
         2'd2: begin
            e.pw = p + 16'd1;
            if (e.pw == 16'h0000) begin e.sw = sr + 16'h0400; e.swe = 1'b1; end
         end
         default: begin
            e.pw = p + 16'd1;
            acc  = e.pw;
            if (e.pw == 16'h0000 && se) begin e.sw = sr + 16'h0400; e.swe = 1'b1; end
         end
      endcase
      seg_src = (f == 2'd3) ? e.sw : sr;
      e.addr  = se ? {seg_src[15:10], acc} : {6'd0, acc};
      e.rd    = iss && (ew[15:12] != 4'hD);
      e.pwe   = e.pwe && iss;
      e.swe   = e.swe && iss;
      return e;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (ext %h ptr %h sr %h issue %0b)",
                  tag, act, exp_v, ext_word, ptr_val, sr_val, issue);
      end
   endtask

   function automatic string form_tag(input logic [1:0] f);
      case (f)
         2'd0:    return "R2";
         2'd1:    return "R3";
         2'd2:    return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic string seg_tag(input logic [1:0] f);
      case (f)
         2'd1:    return "R4";
         2'd2:    return "R5";
         2'd3:    return "R7";
         default: return "R11";
      endcase
   endfunction

   task automatic apply(input logic iss, input logic [15:0] ew,
                        input logic [15:0] p, input logic [15:0] sr);
      exp_t e;
      @(negedge clk);
      issue    = iss;
      ext_word = ew;
      ptr_val  = p;
      sr_val   = sr;
      #(CLK_PERIOD/4);
      e = model(iss, ew, p, sr);
      check("R1", {28'd0, dst_idx}, {28'd0, e.dst});
      check("R1", {28'd0, ptr_idx}, {28'd0, e.pix});
      check(ew[5] ? "R9" : form_tag(ew[4:3]), {10'd0, mem_addr}, {10'd0, e.addr});
      check(iss ? "R8" : "R10", {31'd0, mem_rd}, {31'd0, e.rd});
      check(iss ? form_tag(ew[4:3]) : "R10", {31'd0, ptr_we}, {31'd0, e.pwe});
      if (e.pwe) check(form_tag(ew[4:3]), {16'd0, ptr_wdata}, {16'd0, e.pw});
      check(iss ? seg_tag(ew[4:3]) : "R10", {31'd0, sr_we}, {31'd0, e.swe});
      if (e.swe) check(seg_tag(ew[4:3]), {16'd0, sr_wdata}, {16'd0, e.sw});
   endtask

   function automatic logic [15:0] mk(input logic [3:0] op, input logic [2:0] rx,
                                      input logic seg, input logic [1:0] f,
                                      input logic [2:0] ry);
      return {op, rx, 3'b000, seg, f, ry};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed     = 32'd20240517;
      void'($urandom(seed));
      rst_n    = 1'b0;
      issue    = 1'b0;
      ext_word = 16'h0000;
      ptr_val  = 16'h0000;
      sr_val   = 16'h0000;
      repeat (3) @(posedge clk);
      // R10: reset state, nothing requested while idle
      #1;
      check("R10", {29'd0, mem_rd, ptr_we, sr_we}, 32'd0);
      rst_n = 1'b1;

      // R1 register indices at the extremes
      apply(1'b1, mk(4'h0, 3'd7, 1'b0, 2'd0, 3'd0), 16'h1234, 16'h0000);
      apply(1'b1, mk(4'h0, 3'd0, 1'b0, 2'd0, 3'd7), 16'h1234, 16'h0000);
      // R2 plain indirect, flat and segmented
      apply(1'b1, mk(4'h2, 3'd1, 1'b0, 2'd0, 3'd2), 16'hFFFF, 16'hFC00);
      apply(1'b1, mk(4'h2, 3'd1, 1'b1, 2'd0, 3'd2), 16'hABCD, 16'hA800);
      // R3 / R4 post-decrement, wrap with and without segment enable
      apply(1'b1, mk(4'h1, 3'd3, 1'b0, 2'd1, 3'd4), 16'h0005, 16'h0C00);
      apply(1'b1, mk(4'h1, 3'd3, 1'b0, 2'd1, 3'd4), 16'h0000, 16'h0C3F);
      apply(1'b1, mk(4'h1, 3'd3, 1'b1, 2'd1, 3'd4), 16'h0000, 16'h0000);
      // R5 post-increment wrap, segment enable clear and set, field at max
      apply(1'b1, mk(4'h4, 3'd2, 1'b0, 2'd2, 3'd1), 16'hFFFF, 16'h0401);
      apply(1'b1, mk(4'h4, 3'd2, 1'b1, 2'd2, 3'd1), 16'hFFFF, 16'hFC07);
      // R6 pre-increment, no wrap
      apply(1'b1, mk(4'h6, 3'd5, 1'b0, 2'd3, 3'd6), 16'h7FFF, 16'h1000);
      // R7 pre-increment wrap: gated by segment enable, address uses new field
      apply(1'b1, mk(4'h6, 3'd5, 1'b0, 2'd3, 3'd6), 16'hFFFF, 16'h1000);
      apply(1'b1, mk(4'h6, 3'd5, 1'b1, 2'd3, 3'd6), 16'hFFFF, 16'h1000);
      apply(1'b1, mk(4'h6, 3'd5, 1'b1, 2'd3, 3'd6), 16'hFFFF, 16'hFC55);
      // R8 store form issues no read
      apply(1'b1, mk(4'hD, 3'd0, 1'b1, 2'd2, 3'd0), 16'h0100, 16'h2000);
      apply(1'b1, mk(4'hD, 3'd0, 1'b1, 2'd3, 3'd0), 16'hFFFF, 16'h2000);
      // R10 idle with a wrapping form presented
      apply(1'b0, mk(4'h1, 3'd0, 1'b1, 2'd3, 3'd0), 16'hFFFF, 16'h2000);
      apply(1'b0, mk(4'h1, 3'd0, 1'b0, 2'd1, 3'd0), 16'h0000, 16'h2000);

      // constrained random, biased toward pointer wrap values (R1-R11)
      for (int i = 0; i < N_RANDOM; i++) begin
         logic [15:0] ew;
         logic [15:0] p;
         logic [15:0] sr;
         logic        iss;
         ew  = 16'($urandom());
         sr  = 16'($urandom());
         iss = ($urandom_range(0, 7) != 0);
         case ($urandom_range(0, 3))
            0:       p = 16'hFFFF;
            1:       p = 16'h0000;
            default: p = 16'($urandom());
         endcase
         apply(iss, ew, p, sr);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule